// File: doc/BRIEF.md
# Delayed single-block DMA engine with local byte buffer

The engine copies one block of bytes between a host memory port and a local byte buffer that the engine owns. The buffer appears to software as a fixed window of device addresses starting at `WIN_BASE`. Software fills in four 64-bit registers: source address, destination address, byte count and command. It then sets the run bit in the command register. The engine waits a fixed number of cycles and checks that the buffer-side range fits inside the window. It then moves one byte per host-port handshake, and finally clears run. It can also raise a completion interrupt.

The host side of the transfer is never rejected. Its address is masked to `HOST_AW` bits, so high bits are simply dropped. The buffer side must lie entirely inside the window. If it does not, the transfer is abandoned before any host request and a sticky error flag is set. While run is set, all four registers ignore writes, so the sequencer uses the live register contents as its transfer descriptor.

Top module: `dma_xfer_engine`

## Requirements
- R1: Register offsets are 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command), and all four reset to zero. An 8-byte access (`reg_size`=8) writes or reads all 64 bits. A 4-byte access writes the low 32 bits of `reg_wdata` and zeroes bits 63:32, and a 4-byte read returns the low 32 bits zero-extended.
- R2: An access with a `reg_size` other than 4 or 8 is ignored on write and reads as all ones. A read of any other offset also returns all ones.
- R3: In the command register, bit 0 is run. Bit 1 selects the direction: 0 copies host to buffer, with the source on the host and the destination in the buffer; 1 copies buffer to host. Bit 2 requests the completion interrupt.
- R4: While run is set, writes to any of the four registers leave them unchanged.
- R5: A command write whose bit 0 is clear leaves the command register unchanged and starts nothing.
- R6: The first host request of a transfer appears no earlier than `DELAY_CYC` cycles after the clock edge that accepted the run command.
- R7: A transfer proceeds only if count is nonzero, buffer start ≥ `WIN_BASE` and buffer start + count ≤ `WIN_BASE` + `BUF_BYTES`. Otherwise it makes no host request, clears run, keeps command bits 1 and 2, raises no interrupt and sets `xfer_err`. `xfer_err` stays set until the next run command is accepted.
- R8: The host address of byte i is (host-side register + i) AND (2^`HOST_AW` − 1).
- R9: Byte i is moved between host address (R8) and buffer offset (buffer-side register − `WIN_BASE` + i). Exactly count handshakes are made, so data written to the buffer reads back unchanged.
- R10: Once `host_req` is raised it stays high, with `host_addr` and `host_we` stable, until `host_ack` is sampled high.
- R11: On completion, run is cleared and bits 1 and 2 are kept. If bit 2 was set, `irq_done` goes high and stays high until `irq_ack`. If bit 2 was clear, `irq_done` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access strobe (qualifies writes) |
| reg_we | input | 1 | 1 = write |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 4 | Access width in bytes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational from `reg_addr`/`reg_size` |
| host_req | output | 1 | Host byte request |
| host_we | output | 1 | 1 = host write (buffer to host) |
| host_addr | output | 64 | Masked host byte address |
| host_wdata | output | 8 | Byte written to host |
| host_ack | input | 1 | Host completes the current byte |
| host_rdata | input | 8 | Byte read from host, valid with `host_ack` |
| irq_done | output | 1 | Completion interrupt cause |
| irq_ack | input | 1 | Clears `irq_done` |
| xfer_err | output | 1 | Sticky range-violation flag |

## Verification
The bench targets the window edges. It checks a range that ends exactly at the top of the window and one that ends a byte past it, a start one byte below the base, and a zero count. An engine with an off-by-one in the end comparison would either reject a legal full-window move or read past the buffer. The bench uses host addresses with bits above the mask set: a missing mask shows up as a wrong `host_addr` on the first request. It writes to the registers during the start delay and issues a command with run clear: an unlocked register file would corrupt the running descriptor, and a careless command decode would start a phantom transfer. Random round trips through the buffer, with random host stalls, expose an index that advances without a handshake.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int unsigned REG_W   = 64;
    localparam int unsigned OFS_W   = 8;

    localparam logic [OFS_W-1:0] OFS_SRC = 8'h80;
    localparam logic [OFS_W-1:0] OFS_DST = 8'h88;
    localparam logic [OFS_W-1:0] OFS_CNT = 8'h90;
    localparam logic [OFS_W-1:0] OFS_CMD = 8'h98;

    localparam int unsigned CMD_RUN = 0;
    localparam int unsigned CMD_DIR = 1;
    localparam int unsigned CMD_IRQ = 2;

    typedef struct packed {
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] cmd;
    } dma_regs_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_CHECK,
        SQ_COPY,
        SQ_DONE
    } seq_state_e;

    function automatic logic size_ok(input logic [3:0] sz);
        return (sz == 4'd4) || (sz == 4'd8);
    endfunction

    function automatic logic [REG_W-1:0] size_fit(input logic [REG_W-1:0] v,
                                                  input logic [3:0] sz);
        return (sz == 4'd4) ? {32'd0, v[31:0]} : v;
    endfunction

    function automatic logic range_ok(input logic [REG_W-1:0] start,
                                      input logic [REG_W-1:0] cnt,
                                      input logic [REG_W-1:0] base,
                                      input logic [REG_W-1:0] size);
        logic [REG_W:0] last_x;
        logic [REG_W:0] lim_x;
        last_x = {1'b0, start} + {1'b0, cnt};
        lim_x  = {1'b0, base} + {1'b0, size};
        return (cnt != '0) && (start >= base) && (last_x <= lim_x);
    endfunction

endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
    import dmx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_req,
    input  logic                  reg_we,
    input  logic [OFS_W-1:0]      reg_addr,
    input  logic [3:0]            reg_size,
    input  logic [REG_W-1:0]      reg_wdata,
    input  logic                  seq_finish,
    output logic [REG_W-1:0]      reg_rdata,
    output dma_regs_t             regs,
    output logic                  start
);

    dma_regs_t regs_q;
    logic      wr_ok;
    logic [REG_W-1:0] wval;

    assign wval  = size_fit(reg_wdata, reg_size);
    assign wr_ok = reg_req && reg_we && size_ok(reg_size) && !regs_q.cmd[CMD_RUN];
    assign start = wr_ok && (reg_addr == OFS_CMD) && reg_wdata[CMD_RUN];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (seq_finish) begin
            regs_q.cmd[CMD_RUN] <= 1'b0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_SRC: regs_q.src <= wval;
                OFS_DST: regs_q.dst <= wval;
                OFS_CNT: regs_q.cnt <= wval;
                OFS_CMD: if (reg_wdata[CMD_RUN]) regs_q.cmd <= wval;
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '1;
        if (size_ok(reg_size)) begin
            case (reg_addr)
                OFS_SRC: reg_rdata = size_fit(regs_q.src, reg_size);
                OFS_DST: reg_rdata = size_fit(regs_q.dst, reg_size);
                OFS_CNT: reg_rdata = size_fit(regs_q.cnt, reg_size);
                OFS_CMD: reg_rdata = size_fit(regs_q.cmd, reg_size);
                default: reg_rdata = '1;
            endcase
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/dmx_buf.sv
module dmx_buf #(
    parameter int unsigned BYTES = 4096,
    localparam int unsigned AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
#(
    parameter int unsigned      DELAY_CYC = 100,
    parameter logic [REG_W-1:0] WIN_BASE  = 64'h40000,
    parameter int unsigned      BUF_BYTES = 4096,
    parameter logic [REG_W-1:0] HOST_MASK = 64'h0FFF_FFFF,
    localparam int unsigned     BUF_AW    = $clog2(BUF_BYTES),
    localparam int unsigned     IDX_W     = BUF_AW + 1,
    localparam int unsigned     DLY_W     = $clog2(DELAY_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_W-1:0]  src,
    input  logic [REG_W-1:0]  dst,
    input  logic [REG_W-1:0]  cnt,
    input  logic              dir,
    input  logic              irq_en,
    output logic              host_req,
    output logic              host_we,
    output logic [REG_W-1:0]  host_addr,
    output logic [7:0]        host_wdata,
    input  logic              host_ack,
    input  logic [7:0]        host_rdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              finish,
    output logic              irq_set,
    output logic              err_set
);

    seq_state_e       state_q;
    logic [DLY_W-1:0] dly_q;
    logic [IDX_W-1:0] idx_q;
    logic [REG_W-1:0] buf_base;
    logic [REG_W-1:0] host_base;
    logic             in_window;
    logic             last_byte;

    assign buf_base  = dir ? src : dst;
    assign host_base = dir ? dst : src;
    assign in_window = range_ok(buf_base, cnt, WIN_BASE, REG_W'(BUF_BYTES));
    assign last_byte = (REG_W'(idx_q) + 64'd1) == cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            dly_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q <= SQ_WAIT;
                        dly_q   <= '0;
                    end
                end
                SQ_WAIT: begin
                    if (dly_q == DLY_W'(DELAY_CYC - 1)) state_q <= SQ_CHECK;
                    else                                dly_q   <= dly_q + 1'b1;
                end
                SQ_CHECK: begin
                    idx_q   <= '0;
                    state_q <= in_window ? SQ_COPY : SQ_IDLE;
                end
                SQ_COPY: begin
                    if (host_ack) begin
                        idx_q <= idx_q + 1'b1;
                        if (last_byte) state_q <= SQ_DONE;
                    end
                end
                SQ_DONE:  state_q <= SQ_IDLE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    assign host_req   = (state_q == SQ_COPY);
    assign host_we    = dir;
    assign host_addr  = (host_base + REG_W'(idx_q)) & HOST_MASK;
    assign host_wdata = buf_rdata;

    assign buf_addr  = BUF_AW'(buf_base - WIN_BASE + REG_W'(idx_q));
    assign buf_we    = host_req && host_ack && !dir;
    assign buf_wdata = host_rdata;

    assign err_set = (state_q == SQ_CHECK) && !in_window;
    assign finish  = (state_q == SQ_DONE) || err_set;
    assign irq_set = (state_q == SQ_DONE) && irq_en;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dmx_pkg::*;
#(
    parameter int unsigned      DELAY_CYC = 100,
    parameter logic [63:0]      WIN_BASE  = 64'h40000,
    parameter int unsigned      BUF_BYTES = 4096,
    parameter int unsigned      HOST_AW   = 28
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_req,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [3:0]  reg_size,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        host_req,
    output logic        host_we,
    output logic [63:0] host_addr,
    output logic [7:0]  host_wdata,
    input  logic        host_ack,
    input  logic [7:0]  host_rdata,
    output logic        irq_done,
    input  logic        irq_ack,
    output logic        xfer_err
);

    localparam int unsigned  BUF_AW    = $clog2(BUF_BYTES);
    localparam logic [63:0]  HOST_MASK = (HOST_AW >= 64) ? '1 : ((64'd1 << HOST_AW) - 64'd1);

    dma_regs_t        regs_q;
    logic             start;
    logic             seq_finish;
    logic             irq_set;
    logic             err_set;
    logic             buf_we;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0]       buf_wdata;
    logic [7:0]       buf_rdata;
    logic             irq_q;
    logic             err_q;

    dmx_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_size   (reg_size),
        .reg_wdata  (reg_wdata),
        .seq_finish (seq_finish),
        .reg_rdata  (reg_rdata),
        .regs       (regs_q),
        .start      (start)
    );

    dmx_seq #(
        .DELAY_CYC (DELAY_CYC),
        .WIN_BASE  (WIN_BASE),
        .BUF_BYTES (BUF_BYTES),
        .HOST_MASK (HOST_MASK)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .src        (regs_q.src),
        .dst        (regs_q.dst),
        .cnt        (regs_q.cnt),
        .dir        (regs_q.cmd[CMD_DIR]),
        .irq_en     (regs_q.cmd[CMD_IRQ]),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .buf_rdata  (buf_rdata),
        .finish     (seq_finish),
        .irq_set    (irq_set),
        .err_set    (err_set)
    );

    dmx_buf #(
        .BYTES (BUF_BYTES)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .addr  (buf_addr),
        .wdata (buf_wdata),
        .rdata (buf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (irq_set)      irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;
            if (err_set)      err_q <= 1'b1;
            else if (start)   err_q <= 1'b0;
        end
    end

    assign irq_done = irq_q;
    assign xfer_err = err_q;

endmodule

// File: rtl/dmx_chk.sv
module dmx_chk
    import dmx_pkg::*;
#(
    parameter logic [63:0] MASK = 64'h0FFF_FFFF
) (
    input logic        clk,
    input logic        rst,
    input logic        host_req,
    input logic        host_ack,
    input logic        host_we,
    input logic [63:0] host_addr,
    input logic        irq_done,
    input logic        xfer_err,
    input dma_regs_t   regs
);

    AST_HADDR_MASKED: assert property (@(posedge clk) disable iff (rst)
        host_req |-> ((host_addr & ~MASK) == 64'd0)); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_ack) |=> (host_req && $stable(host_addr) && $stable(host_we))); // R10

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        host_req |-> regs.cmd[CMD_RUN]); // R3

    AST_REGS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        regs.cmd[CMD_RUN] |=> ($stable(regs.src) && $stable(regs.dst) && $stable(regs.cnt))); // R4

    AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_done) |-> $fell(regs.cmd[CMD_RUN])); // R11

    AST_ERR_NO_COPY: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_err) |-> (!host_req && !regs.cmd[CMD_RUN] && !$rose(irq_done))); // R7

endmodule

bind dma_xfer_engine dmx_chk #(.MASK(HOST_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_req  (host_req),
    .host_ack  (host_ack),
    .host_we   (host_we),
    .host_addr (host_addr),
    .irq_done  (irq_done),
    .xfer_err  (xfer_err),
    .regs      (regs_q)
);

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;

    localparam int unsigned DLY  = 20;
    localparam logic [63:0] MASK = 64'h0FFF_FFFF;
    localparam logic [63:0] WIN  = 64'h40000;
    localparam int unsigned BUFN = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        host_req;
    logic        host_we;
    logic [63:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_ack = 1'b0;
    logic [7:0]  host_rdata = 8'h0;
    logic        irq_done;
    logic        irq_ack = 1'b0;
    logic        xfer_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [63:0] exp_hbase = '0;
    int          rsp_n = 0;
    int          addr_bad = 0;
    bit          seen = 0;
    int          first_cyc = 0;
    int          t0 = 0;
    logic [7:0]  wlog [logic [63:0]];

    dma_xfer_engine #(.DELAY_CYC(DLY)) uut (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .irq_done(irq_done), .irq_ack(irq_ack), .xfer_err(xfer_err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] hmem(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // host memory model with random stalls
    always @(negedge clk) begin
        if (host_req && !seen) begin
            seen = 1;
            first_cyc = cyc;
        end
        if (host_ack) begin
            host_ack = 1'b0;
        end else if (host_req && ($urandom % 3) != 0) begin
            if (host_addr != ((exp_hbase + 64'(rsp_n)) & MASK)) addr_bad++;
            if (host_we) wlog[host_addr] = host_wdata;
            else         host_rdata = hmem(host_addr);
            host_ack = 1'b1;
            rsp_n++;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [3:0] s, input logic [63:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, input logic [3:0] s, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a; reg_size = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        for (int i = 0; i < 30000; i++) begin
            reg_rd(8'h98, 4'd8, v);
            if (!v[0]) break;
        end
    endtask

    task automatic launch(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                          input logic [63:0] c, input logic [63:0] hb);
        reg_wr(8'h80, 4'd8, s);
        reg_wr(8'h88, 4'd8, d);
        reg_wr(8'h90, 4'd8, n);
        rsp_n = 0; addr_bad = 0; seen = 0; exp_hbase = hb;
        reg_wr(8'h98, 4'd8, c);
        t0 = cyc;
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    // host -> buffer at boff, then buffer -> host at hdst; compare host writes
    task automatic round_trip(input logic [63:0] hsrc, input logic [63:0] boff,
                              input int n, input logic [63:0] hdst, input string tag);
        int bad;
        logic [63:0] ea;
        launch(hsrc, WIN + boff, 64'(n), 64'h5, hsrc);
        wait_idle();
        check({tag, " R9 fill count"}, 64'(rsp_n), 64'(n));
        check({tag, " R8 fill addr"}, 64'(addr_bad), 64'd0);
        check({tag, " R11 irq raised"}, 64'(irq_done), 64'd1);
        pulse_ack();
        check({tag, " R11 irq cleared"}, 64'(irq_done), 64'd0);
        wlog.delete();
        launch(WIN + boff, hdst, 64'(n), 64'h3, hdst);
        wait_idle();
        check({tag, " R8 drain addr"}, 64'(addr_bad), 64'd0);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            ea = (hdst + 64'(i)) & MASK;
            if (!wlog.exists(ea)) bad++;
            else if (wlog[ea] != hmem((hsrc + 64'(i)) & MASK)) bad++;
        end
        check({tag, " R9 data round trip"}, 64'(bad), 64'd0);
        check({tag, " R11 no irq without bit 2"}, 64'(irq_done), 64'd0);
    endtask

    initial begin
        logic [63:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        reg_rd(8'h80, 4'd8, v); check("R1 src reset", v, 64'd0);
        reg_rd(8'h98, 4'd8, v); check("R1 cmd reset", v, 64'd0);
        check("R7 err reset", 64'(xfer_err), 64'd0);
        check("R11 irq reset", 64'(irq_done), 64'd0);

        // access widths
        reg_wr(8'h88, 4'd8, 64'hFFFF_FFFF_1234_5678);
        reg_rd(8'h88, 4'd8, v); check("R1 8-byte write", v, 64'hFFFF_FFFF_1234_5678);
        reg_rd(8'h88, 4'd4, v); check("R1 4-byte read", v, 64'h1234_5678);
        reg_wr(8'h88, 4'd4, 64'hAAAA_BBBB_CCCC_DDDD);
        reg_rd(8'h88, 4'd8, v); check("R1 4-byte write zero-extends", v, 64'h0000_0000_CCCC_DDDD);
        reg_wr(8'h88, 4'd2, 64'h1);
        reg_rd(8'h88, 4'd8, v); check("R2 odd-size write ignored", v, 64'h0000_0000_CCCC_DDDD);
        reg_rd(8'h88, 4'd1, v); check("R2 odd-size read", v, '1);
        reg_rd(8'h20, 4'd8, v); check("R2 unmapped read", v, '1);

        // command without run
        rsp_n = 0; seen = 0;
        reg_wr(8'h98, 4'd8, 64'h6);
        repeat (DLY + 8) @(negedge clk);
        reg_rd(8'h98, 4'd8, v); check("R5 cmd unchanged", v, 64'd0);
        check("R5 no host request", 64'(seen), 64'd0);

        // delay, masking and lock during the delay
        launch(64'hF_0000_1230, WIN + 64'h10, 64'd16, 64'h5, 64'hF_0000_1230 & MASK);
        reg_wr(8'h80, 4'd8, 64'hDEAD);
        reg_wr(8'h98, 4'd8, 64'h3);
        reg_rd(8'h80, 4'd8, v); check("R4 src locked", v, 64'hF_0000_1230);
        reg_rd(8'h98, 4'd8, v); check("R4 cmd locked", v, 64'h5);
        wait_idle();
        check("R6 start delay lower bound", 64'(first_cyc - t0 >= int'(DLY)), 64'd1);
        check("R6 start delay upper bound", 64'(first_cyc - t0 <= int'(DLY) + 2), 64'd1);
        check("R8 masked host address", 64'(addr_bad), 64'd0);
        reg_rd(8'h98, 4'd8, v); check("R11 run cleared, bits kept", v, 64'h4);
        check("R11 irq after done", 64'(irq_done), 64'd1);
        pulse_ack();

        // range violations
        launch(64'h100, WIN - 64'd1, 64'd4, 64'h5, 64'h100);
        wait_idle();
        check("R7 below base err", 64'(xfer_err), 64'd1);
        check("R7 below base no request", 64'(seen), 64'd0);
        reg_rd(8'h98, 4'd8, v); check("R7 below base cmd", v, 64'h4);
        check("R7 no irq on error", 64'(irq_done), 64'd0);
        launch(64'h100, WIN + BUFN - 64'd4, 64'd5, 64'h1, 64'h100);
        wait_idle();
        check("R7 past end err", 64'(xfer_err), 64'd1);
        check("R7 past end no request", 64'(seen), 64'd0);
        launch(64'h100, WIN, 64'd0, 64'h1, 64'h100);
        wait_idle();
        check("R7 zero count err", 64'(xfer_err), 64'd1);
        check("R7 zero count no request", 64'(seen), 64'd0);
        launch(64'h100, WIN + BUFN - 64'd4, 64'd4, 64'h1, 64'h100);
        @(negedge clk);
        check("R7 err cleared on new start", 64'(xfer_err), 64'd0);
        wait_idle();
        check("R7 exact top edge accepted", 64'(rsp_n), 64'd4);

        // full window
        launch(64'h2000, WIN, 64'(BUFN), 64'h1, 64'h2000);
        wait_idle();
        check("R9 full window count", 64'(rsp_n), 64'(BUFN));
        check("R7 full window no err", 64'(xfer_err), 64'd0);
        round_trip(64'h2000 + BUFN - 8, BUFN - 8, 8, 64'h7_0000_0000, "top edge");

        // random round trips
        for (int k = 0; k < 6; k++) begin
            int n;
            logic [63:0] off;
            n   = 1 + int'($urandom % 48);
            off = 64'($urandom % (BUFN - n + 1));
            round_trip({$urandom, $urandom}, off, n, {$urandom, $urandom}, "random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule